// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of a 12-bit successive-approximation analog-to-digital converter. A start strobe launches a conversion. The sequencer then resolves one bit per clock period, most significant bit first. In each period it drives a trial code to an external DAC. At the end of the period it samples an external comparator, which reports whether that trial code is too high compared with the held analog input.

The trial polarity is inverted. A bit that is not yet tested rests high and is tested by pulling it low. A comparator output of 0 means the DAC level is too high, and the bit then stays low. A comparator output of 1 returns the bit high. When the last bit has been decided, an active-low completion flag falls and the final code is captured in a result register. A read enable drives that register onto a data bus.

The DAC, the comparator and the sampling circuit lie outside the block.

Top module: `sar_seq_core`

## Requirements
- R1: While reset is asserted, and after it until the first start, `trial_o` is 0xFFF (every bit high), `done_n_o` is 1 and `bus_o` is 0.
- R2: A start strobe sampled while idle is accepted. From the next cycle, `trial_o` is 0x7FF: bit 11 is pulled low for trial and every other bit is preset high. `done_n_o` is 1 from that cycle.
- R3: During a conversion exactly one bit is under trial, and it is driven low. Every bit below it is high. Bits are tried from bit 11 down to bit 0, one per clock period.
- R4: The comparator is sampled on the clock edge that ends each bit's trial period. If `cmp_i`=0, the bit stays 0. If `cmp_i`=1, the bit returns to 1. On that same edge the next lower bit is pulled low.
- R5: A conversion lasts exactly 12 clock periods. `done_n_o` falls on the edge that samples the bit-0 decision and stays 0 until the next accepted start.
- R6: A start strobe that arrives while a conversion is running, including during its final period, is ignored. It neither restarts nor extends the conversion.
- R7: After completion, `trial_o` holds the final code unchanged until the next accepted start.
- R8: With `rd_en_i`=1, `bus_o` shows the final code of the most recently completed conversion (0 before any conversion). With `rd_en_i`=0, `bus_o` is 0. That value is kept through a later conversion until that conversion completes.
- R9: A start strobe in the first idle cycle after completion is accepted, and `done_n_o` returns to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, one bit decision per period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Conversion start strobe |
| cmp_i | input | 1 | Comparator result: 0 = DAC level too high, 1 = not too high |
| rd_en_i | input | 1 | Read enable for the result bus |
| trial_o | output | 12 | Trial code to the DAC; holds the final code after completion |
| done_n_o | output | 1 | Active-low conversion-complete flag |
| bus_o | output | 12 | Result register on the data bus when read-enabled, else 0 |

## Verification
The assertions check several rules on every cycle:
- exactly one bit is pulled low during a conversion, and all bits below it sit high;
- each decided bit equals the comparator value sampled one edge earlier;
- a running conversion always lasts twelve periods and ends with the completion flag low;
- a start strobe during a conversion changes neither its course nor the flag;
- the bus stays stable while read-enabled between completions.

Some behaviour only the bench scenarios can show. One is that the final code equals the input level modelled by the bench comparator for codes across the full range, including the extremes and the neighbours of mid-scale. Others are the back-to-back restart right after completion, and a result that persists across a later conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } sar_state_e;

endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  output logic         conv_o,
  output logic [W-1:0] mask_o,
  output logic         launch_o,
  output logic         finish_o,
  output logic         done_n_o
);

  localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

  sar_state_e   state_q, state_d;
  logic [W-1:0] mask_q, mask_d;
  logic         mask_en;
  logic         done_q, done_d, done_en;
  logic         launch, finish;

  // next-state logic
  always_comb begin
    launch  = (state_q == ST_IDLE) && start_i;
    finish  = (state_q == ST_CONV) && mask_q[0];

    state_d = state_q;
    if (launch)      state_d = ST_CONV;
    else if (finish) state_d = ST_IDLE;

    mask_en = launch || (state_q == ST_CONV);
    mask_d  = launch ? MSB_MASK : (mask_q >> 1);

    done_en = launch || finish;
    done_d  = launch;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_q <= 1'b1;
    else if (done_en) done_q <= done_d;
  end

  assign conv_o   = (state_q == ST_CONV);
  assign mask_o   = mask_q;
  assign launch_o = launch;
  assign finish_o = finish;
  assign done_n_o = done_q;

endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         launch_i,
  input  logic         conv_i,
  input  logic [W-1:0] mask_i,
  input  logic         cmp_i,
  output logic [W-1:0] code_o,
  output logic [W-1:0] code_d_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_en, bit_d, bit_q;

    if (i == W-1) begin : g_top
      // top bit: pulled low at launch, decided on its own trial edge
      assign bit_en = launch_i | (conv_i & mask_i[i]);
      assign bit_d  = launch_i ? 1'b0 : cmp_i;
    end else begin : g_low
      // lower bits: preset high at launch, pulled low when the bit above
      // is decided, then take the comparator value on their own edge
      assign bit_en = launch_i | (conv_i & (mask_i[i] | mask_i[i+1]));
      assign bit_d  = launch_i ? 1'b1 : (mask_i[i] & cmp_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b1;
      else if (bit_en) bit_q <= bit_d;
    end

    assign code_o[i]   = bit_q;
    assign code_d_o[i] = bit_en ? bit_d : bit_q;
  end

endmodule

// File: rtl/sar_rd_port.sv
module sar_rd_port #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] code_i,
  input  logic         rd_en_i,
  output logic [W-1:0] bus_o
);

  logic [W-1:0] res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (load_i) res_q <= code_i;
  end

  assign bus_o = rd_en_i ? res_q : '0;

endmodule

// File: rtl/sar_seq_core.sv
module sar_seq_core #(
  parameter int W           = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         cmp_i,
  input  logic         rd_en_i,
  output logic [W-1:0] trial_o,
  output logic         done_n_o,
  output logic [W-1:0] bus_o
);

  logic         rst_sync_n;
  logic         conv;
  logic [W-1:0] mask;
  logic         launch;
  logic         finish;
  logic [W-1:0] code_d;

  sar_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sar_seq_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .conv_o   (conv),
    .mask_o   (mask),
    .launch_o (launch),
    .finish_o (finish),
    .done_n_o (done_n_o)
  );

  sar_code_reg #(.W(W)) u_code (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .launch_i (launch),
    .conv_i   (conv),
    .mask_i   (mask),
    .cmp_i    (cmp_i),
    .code_o   (trial_o),
    .code_d_o (code_d)
  );

  sar_rd_port #(.W(W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_i  (finish),
    .code_i  (code_d),
    .rd_en_i (rd_en_i),
    .bus_o   (bus_o)
  );

endmodule

// File: rtl/sar_seq_core_chk.sv
module sar_seq_core_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         cmp_i,
  input logic         rd_en_i,
  input logic [W-1:0] trial_o,
  input logic         done_n_o,
  input logic [W-1:0] bus_o,
  input logic         conv,
  input logic [W-1:0] mask,
  input logic         finish
);

  localparam int CW = $clog2(W + 1) + 1;

  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (conv) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  AST_ONE_BIT_UNDER_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    conv |-> $onehot(mask)); // R3

  AST_TRIAL_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    conv |-> ((trial_o & mask) == '0)); // R3

  AST_LOWER_BITS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    conv |-> ((trial_o & (mask - 1'b1)) == (mask - 1'b1))); // R3

  AST_BIT_FOLLOWS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    conv |=> ((trial_o & $past(mask)) == ($past(cmp_i) ? $past(mask) : '0))); // R4

  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    conv |-> (run_len <= CW'(W - 1))); // R5

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (conv && run_len == CW'(W - 1)) |=> (!conv && !done_n_o)); // R5

  AST_DONE_HIGH_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    conv |-> done_n_o); // R2

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (conv && start_i && run_len != CW'(W - 1)) |=> (conv && done_n_o)); // R6

  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && $past(rd_en_i) && !$past(finish)) |-> $stable(bus_o)); // R8

endmodule

bind sar_seq_core sar_seq_core_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start_i  (start_i),
  .cmp_i    (cmp_i),
  .rd_en_i  (rd_en_i),
  .trial_o  (trial_o),
  .done_n_o (done_n_o),
  .bus_o    (bus_o),
  .conv     (conv),
  .mask     (mask),
  .finish   (finish)
);

// File: tb/sar_seq_core_tb.sv
`timescale 1ns/1ps
module sar_seq_core_tb;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         rd_en_i = 1'b0;
  logic         cmp_i;
  logic [W-1:0] trial_o;
  logic         done_n_o;
  logic [W-1:0] bus_o;
  logic [W-1:0] vin = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // behavioural comparator: 0 when the DAC code is at or above the input
  assign cmp_i = (trial_o < vin);

  sar_seq_core u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cmp_i    (cmp_i),
    .rd_en_i  (rd_en_i),
    .trial_o  (trial_o),
    .done_n_o (done_n_o),
    .bus_o    (bus_o)
  );

  // cycle-by-cycle reference model
  bit           m_busy;
  int           m_bit;
  logic [W-1:0] m_code;
  logic         m_done_n;
  logic [W-1:0] m_result;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_bit = 0; m_code = '1; m_done_n = 1'b1; m_result = '0;
    end else if (!m_busy) begin
      if (start_i) begin
        m_busy = 1; m_bit = W - 1;
        m_code = '1; m_code[W-1] = 1'b0; m_done_n = 1'b1;
      end
    end else begin
      m_code[m_bit] = (m_code < vin);
      if (m_bit == 0) begin
        m_busy = 0; m_done_n = 1'b0; m_result = m_code;
      end else begin
        m_bit = m_bit - 1;
        m_code[m_bit] = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // advance to the next falling edge and compare against the model
  task automatic tick();
    @(negedge clk);
    chk(trial_o == m_code, "R3/R4 trial code vs model", int'(trial_o), int'(m_code));
    chk(done_n_o == m_done_n, "R5 done flag vs model", int'(done_n_o), int'(m_done_n));
    chk(bus_o == (rd_en_i ? m_result : '0), "R8 bus vs model", int'(bus_o),
        int'(rd_en_i ? m_result : '0));
  endtask

  // run one conversion; stray_at >= 0 injects a start in that period
  task automatic convert(input int level, input int stray_at, input bit idle_after,
                         input int prev_res);
    int n;
    vin = level[W-1:0];
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk(trial_o == 12'h7FF, "R2 first trial code", int'(trial_o), 'h7FF);
    chk(done_n_o == 1'b1, "R2 done high after start", int'(done_n_o), 1);
    n = 0;
    while (done_n_o == 1'b1 && n < 20) begin
      start_i = (n == stray_at);
      tick();
      n++;
      if (n == 6) begin
        rd_en_i = 1'b1;
        #0.1;
        chk(bus_o == prev_res[W-1:0], "R8 result held during conversion",
            int'(bus_o), prev_res);
      end
    end
    start_i = 1'b0;
    chk(n == W, "R5 conversion period count", n, W);
    chk(trial_o == level[W-1:0], "R4 final code", int'(trial_o), level);
    rd_en_i = 1'b1;
    #0.1;
    chk(bus_o == level[W-1:0], "R8 bus shows result", int'(bus_o), level);
    if (stray_at >= 0) begin
      tick();
      chk(done_n_o == 1'b0, "R6 stray start ignored", int'(done_n_o), 0);
    end
    if (idle_after) begin
      rd_en_i = 1'b0;
      tick();
      chk(bus_o == '0, "R8 bus zero without enable", int'(bus_o), 0);
      tick();
      chk(trial_o == level[W-1:0], "R7 final code held", int'(trial_o), level);
      chk(done_n_o == 1'b0, "R5 done stays low", int'(done_n_o), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rd_en_i = 1'b1;
    #0.1;
    chk(trial_o == 12'hFFF, "R1 reset trial code", int'(trial_o), 'hFFF);
    chk(done_n_o == 1'b1, "R1 reset done flag", int'(done_n_o), 1);
    chk(bus_o == '0, "R1 reset bus", int'(bus_o), 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk(trial_o == 12'hFFF, "R1 idle trial code", int'(trial_o), 'hFFF);
    rd_en_i = 1'b0;

    convert(0,     -1, 1'b1, 0);
    convert(4095,   3, 1'b1, 0);
    convert(2048,  -1, 1'b1, 4095);
    convert(2047,  11, 1'b1, 2048);
    convert(1,      0, 1'b1, 2047);
    convert('hA5C, -1, 1'b0, 1);
    // back-to-back restart in the first idle cycle
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk(done_n_o == 1'b1, "R9 done returns high on restart", int'(done_n_o), 1);
    chk(trial_o == 12'h7FF, "R9 restart trial code", int'(trial_o), 'h7FF);
    vin = 12'h3C3;
    repeat (W) tick();
    chk(done_n_o == 1'b0, "R9 restarted conversion completes", int'(done_n_o), 0);
    chk(trial_o == 12'h3C3, "R9 restarted final code", int'(trial_o), 'h3C3);
    convert('h5A5, 5, 1'b1, 'h3C3);
    repeat (3) tick();

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule